// File: doc/BRIEF.md
# Parameterised Wallace-Tree Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and presents the full product on a `2*WIDTH`-bit output. It is purely combinational and has no clock or reset. A datapath that needs a product registers the output wherever its own timing allows. Any `WIDTH` of 2 or more is supported. The block is meant for use at 8 bits and at 64 bits.

Inside the block, a grid of two-input AND gates first builds one shifted row per bit of the second operand. A Wallace-style tree then compresses these rows one stage at a time. In each stage the rows are taken in consecutive, non-overlapping triples. Each triple becomes two rows: one of column-wise sums, and one of column-wise carries moved up one column. Rows left over at the end of a stage go to the next stage untouched. Compression stops when two rows remain. A Sklansky parallel-prefix adder then adds those two rows. Its carry chain is logarithmic in depth where a ripple-carry adder would be linear.

Top module: `wallace_mult`

## Requirements
- R1: `product` equals the exact unsigned product `op_a * op_b` for every pair of operand values.
- R2: Partial-product row j holds `op_a & {WIDTH{op_b[j]}}` shifted left by j places, so bit a[i]&b[j] carries weight 2^(i+j) and row j has zeros in its j lowest positions.
- R3: Each reduction stage splits its rows into non-overlapping groups of three neighbouring rows. Each group is replaced by a sum row (a^b^c per column) and a carry row (majority per column, moved one column up). Rows that do not fill a whole group pass through unchanged, and the total value of all rows does not change from one stage to the next.
- R4: No carry is ever lost above bit 2*WIDTH-1, whether in a reduction stage or in the final adder.
- R5: The final adder output equals the sum of its two input rows modulo 2^(2*WIDTH). Its carry into each bit comes from a prefix network of generate = x&y and propagate = x^y terms.
- R6: A zero in either operand gives a product of zero.
- R7: All-ones times all-ones gives 2^(2*WIDTH) - 2^(WIDTH+1) + 1.
- R8: Single-bit operands 2^i and 2^j give exactly 2^(i+j).
- R9: The same source gives correct products at `WIDTH` = 8 and at `WIDTH` = 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier; bit j selects partial-product row j |
| product | output | 2*WIDTH | Full unsigned product |

## Verification
At 8 bits the bench drives all 65,536 operand pairs. That catches any wrong wiring in the tree: a misrouted carry, a dropped leftover row, or a lost column. Each of these gives a wrong product for some operand pattern. At 64 bits the bench drives all-ones operands, which exercise the longest carry chain; a broken prefix link or a dropped top carry would then show up in the upper half of the product. Power-of-two operands catch a partial-product row shifted by the wrong amount, which would place the single set bit in the wrong position. Zero operands catch a stray constant or a carry injected into the final adder.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // Rows left after one stage that takes rows in groups of three.
  function automatic int rows_next(input int rows);
    return (rows / 3) * 2 + (rows % 3);
  endfunction

  // Rows present at the input of stage s for an n-bit multiplier.
  function automatic int rows_at(input int n, input int s);
    int r;
    r = n;
    for (int k = 0; k < s; k++) r = rows_next(r);
    return r;
  endfunction

  // Number of stages needed to reach two rows.
  function automatic int stage_count(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = rows_next(r);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/pp_array.sv
module pp_array #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] rows [N]
);

  localparam int W = 2 * N;

  for (genvar j = 0; j < N; j++) begin : g_row
    logic [W-1:0] ext;
    assign ext     = {{N{1'b0}}, a & {N{b[j]}}};
    assign rows[j] = ext << j;
  end

  // R2: each row is a copy of a gated by b[j] and sits j columns up
  always_comb begin
    for (int j = 0; j < N; j++) begin
      a_r2_pp_row: assert ($countones(rows[j]) == (b[j] ? $countones(a) : 0))
        else $error("row %0d has wrong bit count", j);
      a_r2_pp_low_zero: assert ((rows[j] & ((W'(1) << j) - W'(1))) == '0)
        else $error("row %0d low columns not clear", j);
    end
  end

endmodule

// File: rtl/wallace_stage.sv
module wallace_stage #(
  parameter int W  = 16,
  parameter int RI = 8
) (
  input  logic [W-1:0] rin  [RI],
  output logic [W-1:0] rout [(RI / 3) * 2 + (RI % 3)]
);

  localparam int NG = RI / 3;
  localparam int NL = RI % 3;
  localparam int RO = 2 * NG + NL;

  logic [NG-1:0] lost;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [W-1:0] x, y, z, cy;
    assign x = rin[3*g];
    assign y = rin[3*g+1];
    assign z = rin[3*g+2];
    // full adder in every column; constant-zero inputs fold away
    assign rout[2*g] = x ^ y ^ z;
    assign cy        = (x & y) | (y & z) | (z & x);
    assign rout[2*g+1] = {cy[W-2:0], 1'b0};
    assign lost[g]     = cy[W-1];
  end

  for (genvar k = 0; k < NL; k++) begin : g_pass
    assign rout[2*NG+k] = rin[3*NG+k];
  end

  logic [W-1:0] sum_in;
  logic [W-1:0] sum_out;

  always_comb begin
    sum_in  = '0;
    sum_out = '0;
    for (int k = 0; k < RI; k++) sum_in  = sum_in  + rin[k];
    for (int k = 0; k < RO; k++) sum_out = sum_out + rout[k];
    // R3: compression keeps the total of all rows
    a_r3_value_kept: assert (sum_in == sum_out)
      else $error("stage changed row total");
    // R4: no carry falls off the top column
    a_r4_no_overflow: assert (lost == '0)
      else $error("carry lost above top column");
  end

endmodule

// File: rtl/sklansky_adder.sv
module sklansky_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int L = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] gl [L+1];
  logic [W-1:0] pl [L+1];
  logic [W-1:0] p0;
  logic [W-1:0] cin;

  assign p0    = x ^ y;
  assign gl[0] = x & y;
  assign pl[0] = p0;

  for (genvar k = 0; k < L; k++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (((i >> k) & 1) == 1) begin : g_merge
        localparam int J = ((i >> k) << k) - 1;
        assign gl[k+1][i] = gl[k][i] | (pl[k][i] & gl[k][J]);
        assign pl[k+1][i] = pl[k][i] & pl[k][J];
      end else begin : g_keep
        assign gl[k+1][i] = gl[k][i];
        assign pl[k+1][i] = pl[k][i];
      end
    end
  end

  assign cin  = {gl[L][W-2:0], 1'b0};
  assign sum  = p0 ^ cin;
  assign cout = gl[L][W-1];

  // R5: the prefix result matches a plain addition
  always_comb begin
    a_r5_prefix_sum: assert (sum == x + y)
      else $error("prefix adder sum wrong");
  end

endmodule

// File: rtl/wallace_mult.sv
module wallace_mult #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] product
);

  localparam int W      = 2 * WIDTH;
  localparam int STAGES = wt_pkg::stage_count(WIDTH);

  logic [W-1:0] pp [WIDTH];
  logic [W-1:0] row_x;
  logic [W-1:0] row_y;
  logic         top_carry;

  pp_array #(.N(WIDTH)) u_pp (
    .a   (op_a),
    .b   (op_b),
    .rows(pp)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    localparam int RI = wt_pkg::rows_at(WIDTH, s);
    localparam int RO = wt_pkg::rows_next(RI);
    logic [W-1:0] rin  [RI];
    logic [W-1:0] rout [RO];
    if (s == 0) begin : g_first
      assign rin = pp;
    end else begin : g_next
      assign rin = g_stg[s-1].rout;
    end
    wallace_stage #(.W(W), .RI(RI)) u_stage (
      .rin (rin),
      .rout(rout)
    );
  end

  if (STAGES > 0) begin : g_rows_tree
    assign row_x = g_stg[STAGES-1].rout[0];
    assign row_y = g_stg[STAGES-1].rout[1];
  end else begin : g_rows_direct
    assign row_x = pp[0];
    assign row_y = pp[1];
  end

  sklansky_adder #(.W(W)) u_cpa (
    .x   (row_x),
    .y   (row_y),
    .sum (product),
    .cout(top_carry)
  );

  always_comb begin
    // R1: full unsigned product
    a_r1_product: assert (product == ({{WIDTH{1'b0}}, op_a} * {{WIDTH{1'b0}}, op_b}))
      else $error("product mismatch");
    // R4: final adder never carries out of the top bit
    a_r4_final_no_carry: assert (!top_carry)
      else $error("final adder carry out");
  end

endmodule

// File: tb/test_wallace_mult.sv
module test_wallace_mult;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]   a8, b8;
  logic [15:0]  p8;
  logic [63:0]  a64, b64;
  logic [127:0] p64;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  wallace_mult #(.WIDTH(8)) i_wallace_mult (
    .op_a(a8), .op_b(b8), .product(p8)
  );

  wallace_mult #(.WIDTH(64)) i_wallace_mult_w64 (
    .op_a(a64), .op_b(b64), .product(p64)
  );

  task automatic check(input string req, input logic [127:0] got,
                       input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] ref64(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] acc;
    acc = '0;
    for (int i = 0; i < 64; i++)
      if (y[i]) acc = acc + ({64'b0, x} << i);
    return acc;
  endfunction

  task automatic drive64(input logic [63:0] x, input logic [63:0] y,
                         input string req);
    @(posedge clk);
    a64 = x;
    b64 = y;
    @(negedge clk);
    check(req, p64, ref64(x, y));
  endtask

  initial begin
    a8 = '0; b8 = '0; a64 = '0; b64 = '0;
    @(negedge clk);
    // R6: zero inputs at start give zero
    check("R6 zero start 8", {112'b0, p8}, '0);
    check("R6 zero start 64", p64, '0);

    // R1 R2 R3 R9: exhaustive 8-bit sweep with random 64-bit traffic alongside
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        logic [63:0] ra, rb;
        ra = {$urandom, $urandom};
        rb = {$urandom, $urandom};
        @(posedge clk);
        a8 = 8'(x); b8 = 8'(y);
        a64 = ra;   b64 = rb;
        @(negedge clk);
        check("R1 R3 exhaustive 8", {112'b0, p8}, 128'(x * y));
        if ((x % 16) == 0) check("R9 random 64", p64, ref64(ra, rb));
      end
    end

    // R7: all ones at both widths
    @(posedge clk);
    a8 = 8'hFF; b8 = 8'hFF;
    @(negedge clk);
    check("R7 ones 8", {112'b0, p8}, 128'hFE01);
    drive64('1, '1, "R7 ones 64");
    check("R7 ones 64 closed form", p64,
          128'h1 - (128'h1 << 65));

    // R6: zero against all ones, either side
    drive64('0, '1, "R6 zero a 64");
    drive64('1, '0, "R6 zero b 64");
    check("R6 zero value", p64, '0);

    // R8 R2: single-bit operands land on bit i+j
    for (int i = 0; i < 64; i += 7) begin
      for (int j = 0; j < 64; j += 9) begin
        drive64(64'b1 << i, 64'b1 << j, "R2 R8 single bit");
        check("R8 one-hot position", p64, 128'b1 << (i + j));
      end
    end
    drive64(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R8 top bits");
    check("R8 top bit value", p64, 128'b1 << 126);

    // R4 R5: long carry chains near the top of the product
    drive64('1, 64'h1, "R5 ones times one");
    drive64('1, 64'h2, "R5 ones times two");
    drive64(64'hFFFF_FFFF_FFFF_FFFE, '1, "R4 near max");
    drive64(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, "R5 alternating");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule